// File: doc/BRIEF.md
# Cross-Domain Width Gearbox

The gearbox carries a continuous bit stream from a writer clock domain to an unrelated reader clock domain and changes the word width on the way. Both sides share one ring of storage bits. On every writer clock the input word goes into the next writer-sized slot of the ring. On every reader clock a registered multiplexer picks the next reader-sized slot of the ring and presents it as the output word. There is no flow control. The two clocks must run at rates whose ratio matches the width ratio, so that both sides move through the ring at the same number of bits per unit time.

The ring is sized at elaboration time. The size starts from the least common multiple of the two widths and doubles until each side has at least four slots. This keeps a spare slot between the writer and the reader on both sides. It also keeps coprime ratios such as 5 to 4 small. After reset the reader starts half-way round the ring from the writer. Each domain has its own synchronous reset. The block holds no combined or resynchronised reset.

Top module: `gbx_width_bridge`

## Requirements
- R1: The ring holds N bits. N starts at lcm(IN_W, OUT_W) and is doubled while N/IN_W < 4 or N/OUT_W < 4. For example, (5,4)→20, (8,8)→32, (4,8)→32, (3,5)→30, (16,10)→80, (2,3)→12, (1,1)→4 and (12,8)→48.
- R2: While `wr_rst` is high at a `wr_clk` edge, every ring bit clears to 0 and the writer slot returns to 0. While `rd_rst` is high at a `rd_clk` edge, `rd_data` becomes 0 and the reader slot returns to floor((N/OUT_W)/2).
- R3: On each `wr_clk` edge out of reset, `wr_data` is stored at ring bits [k*IN_W +: IN_W], where k is the current writer slot. k then steps by one and wraps from N/IN_W-1 to 0.
- R4: On each `rd_clk` edge out of reset, `rd_data` takes ring bits [j*OUT_W +: OUT_W], where j is the current reader slot. j then steps by one and wraps from N/OUT_W-1 to 0. This includes slot counts that are not a power of two, such as 5.
- R5: Each reset acts only on its own side. Holding `rd_rst` keeps `rd_data` at 0 and does not disturb the writer or the ring. Holding `wr_rst` clears the ring but leaves the reader slot running.
- R6: With clock rates in the width ratio, after the start-up latency the output bits reproduce the input bit stream in order (bit 0 of each word first), at a constant bit offset.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Writer-domain clock |
| wr_rst | input | 1 | Writer-domain synchronous reset, active high |
| wr_data | input | IN_W | Input word, stored once per writer clock |
| rd_clk | input | 1 | Reader-domain clock |
| rd_rst | input | 1 | Reader-domain synchronous reset, active high |
| rd_data | output | OUT_W | Output word, registered in the reader domain |

## Verification
The assertions assume that each reset is driven cleanly in its own domain and that the writer and reader clocks never share an edge. Without that, the ring slot being read could change during the capture. The bench keeps within these assumptions. It uses a 10 ns writer clock and an 8 ns reader clock with a 5:4 width ratio, so the rising edges fall at odd and even nanoseconds and never coincide. It changes each reset and each input word only on a falling edge of its own clock.

// File: rtl/gbx_pkg.sv
package gbx_pkg;

   function automatic int gcd_f(input int a, input int b);
      int x;
      int y;
      int t;
      x = a;
      y = b;
      while (y != 0) begin
         t = x % y;
         x = y;
         y = t;
      end
      return x;
   endfunction

   function automatic int lcm_f(input int a, input int b);
      return (a / gcd_f(a, b)) * b;
   endfunction

   // Smallest lcm * 2^m giving every side at least four slots.
   function automatic int ring_bits(input int iw, input int ow);
      int n;
      n = lcm_f(iw, ow);
      while ((n / iw) < 4 || (n / ow) < 4) n = n * 2;
      return n;
   endfunction

endpackage

// File: rtl/gbx_chunk_ptr.sv
module gbx_chunk_ptr #(
   parameter int COUNT = 5,
   parameter int INIT  = 0,
   localparam int PW   = $clog2(COUNT)
) (
   input  logic          clk,
   input  logic          rst,
   output logic [PW-1:0] ptr
);
   localparam logic [PW-1:0] LAST  = PW'(COUNT - 1);
   localparam logic [PW-1:0] START = PW'(INIT);
   localparam bit POW2 = ((COUNT & (COUNT - 1)) == 0);

   if (COUNT < 2) begin : g_bad_count
      $error("gbx_chunk_ptr: COUNT must be at least 2");
   end
   if (INIT < 0 || INIT >= COUNT) begin : g_bad_init
      $error("gbx_chunk_ptr: INIT outside slot range");
   end

   if (POW2) begin : g_wrap_free
      always_ff @(posedge clk) begin
         if (rst) ptr <= START;
         else     ptr <= ptr + 1'b1;
      end
   end else begin : g_wrap_cmp
      always_ff @(posedge clk) begin
         if (rst)               ptr <= START;
         else if (ptr == LAST)  ptr <= '0;
         else                   ptr <= ptr + 1'b1;
      end
   end

   // R3 / R4: slot index stays inside the ring
   a_r3_r4_ptr_range: assert property (@(posedge clk) disable iff (rst)
      ptr <= LAST);

   // R3 / R4: one slot per clock, wrapping after the last slot
   a_r3_r4_ptr_step: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> ptr == (($past(ptr) == LAST) ? '0 : $past(ptr) + 1'b1));

   // R2: slot index restarts at its initial phase
   a_r2_ptr_init: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> ptr == START);

endmodule

// File: rtl/gbx_ring_store.sv
module gbx_ring_store #(
   parameter int IN_W      = 5,
   parameter int RING_BITS = 20,
   localparam int SLOTS    = RING_BITS / IN_W,
   localparam int PW       = $clog2(SLOTS)
) (
   input  logic                 wclk,
   input  logic                 wrst,
   input  logic [PW-1:0]        wptr,
   input  logic [IN_W-1:0]      din,
   output logic [RING_BITS-1:0] ring
);
   if (RING_BITS % IN_W != 0) begin : g_bad_ring
      $error("gbx_ring_store: ring size not a multiple of IN_W");
   end

   for (genvar k = 0; k < SLOTS; k++) begin : g_slot
      logic [IN_W-1:0] slot_q;

      always_ff @(posedge wclk) begin
         if (wrst)                   slot_q <= '0;
         else if (wptr == PW'(k))    slot_q <= din;
      end

      assign ring[k*IN_W +: IN_W] = slot_q;

      // R3: the addressed slot receives the input word
      a_r3_slot_load: assert property (@(posedge wclk) disable iff (wrst)
         (!$past(wrst) && $past(wptr) == PW'(k)) |-> ring[k*IN_W +: IN_W] == $past(din));

      // R3: slots not addressed keep their contents
      a_r3_slot_hold: assert property (@(posedge wclk) disable iff (wrst)
         (!$past(wrst) && $past(wptr) != PW'(k)) |-> $stable(ring[k*IN_W +: IN_W]));
   end

   // R2: writer reset empties the whole ring
   a_r2_ring_clear: assert property (@(posedge wclk) disable iff (wrst)
      $past(wrst) |-> ring == '0);

endmodule

// File: rtl/gbx_read_mux.sv
module gbx_read_mux #(
   parameter int OUT_W     = 4,
   parameter int RING_BITS = 20,
   localparam int SLOTS    = RING_BITS / OUT_W,
   localparam int PW       = $clog2(SLOTS)
) (
   input  logic                 rclk,
   input  logic                 rrst,
   input  logic [PW-1:0]        rptr,
   input  logic [RING_BITS-1:0] ring,
   output logic [OUT_W-1:0]     dout
);
   if (RING_BITS % OUT_W != 0) begin : g_bad_ring
      $error("gbx_read_mux: ring size not a multiple of OUT_W");
   end

   logic [OUT_W-1:0] pick;

   always_comb begin
      pick = '0;
      for (int j = 0; j < SLOTS; j++) begin
         if (rptr == PW'(j)) pick = ring[j*OUT_W +: OUT_W];
      end
   end

   // Capture of writer-domain storage into the reader domain, by design.
   always_ff @(posedge rclk) begin
      if (rrst) dout <= '0;
      else      dout <= pick;
   end

   // R5: output idles at zero right after a reader reset
   a_r5_dout_reset: assert property (@(posedge rclk) disable iff (rrst)
      $past(rrst) |-> dout == '0);

endmodule

// File: rtl/gbx_width_bridge.sv
module gbx_width_bridge #(
   parameter int IN_W  = 5,
   parameter int OUT_W = 4
) (
   input  logic             wr_clk,
   input  logic             wr_rst,
   input  logic [IN_W-1:0]  wr_data,
   input  logic             rd_clk,
   input  logic             rd_rst,
   output logic [OUT_W-1:0] rd_data
);
   localparam int RING_BITS = gbx_pkg::ring_bits(IN_W, OUT_W);
   localparam int WR_SLOTS  = RING_BITS / IN_W;
   localparam int RD_SLOTS  = RING_BITS / OUT_W;
   localparam int WPW       = $clog2(WR_SLOTS);
   localparam int RPW       = $clog2(RD_SLOTS);
   localparam int RD_START  = RD_SLOTS / 2;

   if (IN_W < 1 || OUT_W < 1) begin : g_bad_width
      $error("gbx_width_bridge: widths must be positive");
   end
   if (WR_SLOTS < 4 || RD_SLOTS < 4) begin : g_bad_size
      $error("gbx_width_bridge: ring sizing rule violated");
   end

   logic [WPW-1:0]       wptr;
   logic [RPW-1:0]       rptr;
   logic [RING_BITS-1:0] ring;

   gbx_chunk_ptr #(.COUNT(WR_SLOTS), .INIT(0)) u_wptr (
      .clk (wr_clk),
      .rst (wr_rst),
      .ptr (wptr)
   );

   gbx_chunk_ptr #(.COUNT(RD_SLOTS), .INIT(RD_START)) u_rptr (
      .clk (rd_clk),
      .rst (rd_rst),
      .ptr (rptr)
   );

   gbx_ring_store #(.IN_W(IN_W), .RING_BITS(RING_BITS)) u_store (
      .wclk (wr_clk),
      .wrst (wr_rst),
      .wptr (wptr),
      .din  (wr_data),
      .ring (ring)
   );

   gbx_read_mux #(.OUT_W(OUT_W), .RING_BITS(RING_BITS)) u_mux (
      .rclk (rd_clk),
      .rrst (rd_rst),
      .rptr (rptr),
      .ring (ring),
      .dout (rd_data)
   );

endmodule

// File: tb/gbx_width_bridge_tb_top.sv
module gbx_width_bridge_tb_top;
   localparam int IW = 5;
   localparam int OW = 4;
   localparam int RB = 20;
   localparam int IC = 4;
   localparam int OC = 5;

   // R1 sizing vectors: {in width, out width, ring bits}
   localparam int TV [0:7][0:2] = '{
      '{5, 4, 20}, '{8, 8, 32}, '{4, 8, 32}, '{3, 5, 30},
      '{16, 10, 80}, '{2, 3, 12}, '{1, 1, 4}, '{12, 8, 48}
   };

   logic wclk = 1'b0;
   logic rclk = 1'b0;
   logic wrst = 1'b1;
   logic rrst = 1'b1;
   logic [IW-1:0] din = '0;
   logic [OW-1:0] dout;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 0;
   bit cmp_on = 0;
   bit rec = 0;
   bit rec_out = 0;

   logic [RB-1:0] m_ring = '0;
   int m_w = 0;
   int m_r = OC / 2;
   logic [OW-1:0] m_dout = '0;

   bit in_hist [0:8191];
   int in_bits = 0;
   logic [OW-1:0] out_hist [0:2047];
   int out_n = 0;

   gbx_width_bridge #(.IN_W(IW), .OUT_W(OW)) dut_i (
      .wr_clk  (wclk),
      .wr_rst  (wrst),
      .wr_data (din),
      .rd_clk  (rclk),
      .rd_rst  (rrst),
      .rd_data (dout)
   );

   initial forever #5 wclk = ~wclk;
   initial forever #4 rclk = ~rclk;

   task automatic chk(input string tag, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   function automatic logic [IW-1:0] pat(input int k);
      return IW'((k * 11) + (k >> 3) + 3);
   endfunction

   // Writer-side reference built from R2, R3
   always @(posedge wclk) begin
      if (wrst) begin
         m_ring <= '0;
         m_w <= 0;
      end else begin
         m_ring[m_w*IW +: IW] <= din;
         m_w <= (m_w + 1) % IC;
         if (rec && in_bits < 8000) begin
            for (int b = 0; b < IW; b++) in_hist[in_bits + b] = din[b];
            in_bits += IW;
         end
      end
   end

   // Reader-side reference built from R2, R4
   always @(posedge rclk) begin
      if (rrst) begin
         m_dout <= '0;
         m_r <= OC / 2;
      end else begin
         m_dout <= m_ring[m_r*OW +: OW];
         m_r <= (m_r + 1) % OC;
      end
   end

   always @(negedge rclk) begin
      if (cmp_on) begin
         if (rrst) chk("R5 dout during read reset", int'(dout), int'(m_dout));
         else      chk("R3,R4 dout vs slot model", int'(dout), int'(m_dout));
         if (rec_out && out_n < 2048) begin
            out_hist[out_n] = dout;
            out_n++;
         end
      end
   end

   // Writer stimulus on falling edges
   initial begin
      int k;
      k = 0;
      forever begin
         @(negedge wclk);
         din = pat(k);
         k++;
      end
   end

   initial begin
      #1_000_000;
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog expired before end of test");
         summary();
         $finish;
      end
   end

   initial begin
      int found;
      int best;
      repeat (4) @(negedge wclk);
      @(negedge rclk);
      chk("R2 dout under reset", int'(dout), 0);
      cmp_on = 1;

      @(negedge wclk);
      wrst = 1'b0;
      rec = 1;
      @(negedge rclk);
      rrst = 1'b0;
      rec_out = 1;
      @(negedge rclk);
      chk("R2 first read after reset is zero ring", int'(dout), 0);
      repeat (300) @(negedge rclk);
      rec = 0;
      rec_out = 0;

      // R6: output bits equal input bits at one constant offset
      found = 0;
      best = 0;
      for (int d = -256; d <= 256 && found == 0; d++) begin
         int ok;
         ok = 1;
         for (int n = 40; n < out_n && ok == 1; n++) begin
            for (int b = 0; b < OW; b++) begin
               int ip;
               ip = n * OW + b + d;
               if (ip < 0 || ip >= in_bits) ok = 0;
               else if (in_hist[ip] != out_hist[n][b]) ok = 0;
            end
         end
         if (ok == 1) begin
            found = 1;
            best = d;
         end
      end
      chk("R6 stream reproduced in order", found, 1);
      if (found == 1) $display("R6 stream offset %0d bits", best);

      // R5: reader reset alone
      rrst = 1'b1;
      repeat (6) @(negedge rclk);
      chk("R5 dout held at zero in read reset", int'(dout), 0);
      rrst = 1'b0;
      repeat (100) @(negedge rclk);

      // R5: writer reset alone, reader keeps cycling
      @(negedge wclk);
      wrst = 1'b1;
      repeat (6) @(negedge wclk);
      wrst = 1'b0;
      repeat (100) @(negedge rclk);
      cmp_on = 0;

      // R1 sizing table
      for (int i = 0; i < 8; i++) begin
         chk("R1 ring size", gbx_pkg::ring_bits(TV[i][0], TV[i][1]), TV[i][2]);
      end

      done = 1;
      summary();
      $finish;
   end

endmodule